// File: doc/BRIEF.md
# Byte-Serial Packet Transmitter with Chaining and Pushback

This block takes 104-bit transaction packets from a valid/ready source and sends them out one byte per clock on an 8-bit data lane, with a framing signal that is high while bytes belong to a transaction. It picks the number of bytes per packet from the packet header. Reads and 64-bit writes go out as a 13-byte frame. All other writes go out as a 9-byte frame that leaves off the trailing 32-bit word.

When a packet with an identical header byte is ready on the last byte of the current packet, the block chains it. The frame stays high and the new packet begins at its data field (byte 5). The address bytes are left out because the far end infers them. When the packet cannot be chained, the frame drops for at least one cycle and the next packet starts again from its header byte.

The far end has two pushback inputs. One holds back read packets and the other holds back write packets. These inputs are checked only when a new packet would start. A packet already on the wire always completes.

Top module: `tx_link_serializer`

## Requirements
- R1: While reset is held and after it is released with nothing to send, `tx_frame` is 0 and `tx_data` is 0. With no pushback, `in_ready` is 1.
- R2: Wire byte k of a packet is `in_pkt[103-8k -: 8]`. Byte 0 is the header byte: bit 103 is the write flag (1 = write, 0 = read), bits 102:101 are the size code, bits 100:97 are a control tag and bit 96 is spare. Bytes 1–4 are the address, bytes 5–8 are the data word and bytes 9–12 are the extra word, each most significant byte first.
- R3: A write whose size code is not 2'b11 is sent as bytes 0 through 8 (9 bytes).
- R4: A read (bit 103 = 0), or a write with size code 2'b11, is sent as bytes 0 through 12 (13 bytes).
- R5: A packet can be accepted during the last byte of the current packet only if its header byte equals the current packet's header byte. It is then sent starting at byte 5 in the very next cycle, and `tx_frame` stays 1.
- R6: A packet that cannot be chained is held off. `tx_frame` drops to 0 for at least one cycle, during which `tx_data` is 0, and the packet then starts at byte 0.
- R7: While `rd_wait` is 1, no read packet is accepted (`in_ready` is 0 for it). Write packets are not affected by `rd_wait`.
- R8: While `wr_wait` is 1, no write packet is accepted. Read packets are not affected by `wr_wait`.
- R9: A pushback input that rises while a packet is being sent does not shorten that packet. All of its bytes are sent.
- R10: From idle, a packet accepted on a clock edge has its byte 0 on `tx_data`, with `tx_frame` at 1, right after that edge. `in_ready` is 0 in every cycle of a packet except its last byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Source offers a packet |
| in_ready | output | 1 | Packet is taken on this edge if `in_valid` is 1 (depends on the offered header) |
| in_pkt | input | 104 | Offered packet |
| rd_wait | input | 1 | Far end cannot take more reads |
| wr_wait | input | 1 | Far end cannot take more writes |
| tx_frame | output | 1 | High while transaction bytes are on `tx_data` |
| tx_data | output | 8 | Outgoing byte |

## Verification
`in_ready` is combinational in the current cycle. Byte 0 or byte 5 of an accepted packet appears in the cycle that follows the accepting edge, and each later byte follows one cycle after the previous one. An unchained packet sees exactly one low-frame cycle before byte 0 when nothing else holds it back. The bench drives inputs and samples outputs on the falling edge and logs one (frame, byte) pair per cycle. Without pushback, it compares that log cycle by cycle against a trace built from the requirements. With pushback, where the gap length is set by the test, it collapses each low-frame run to one entry before comparing.

// File: rtl/tx_ser_pkg.sv
package tx_ser_pkg;
  localparam int BYTE_W      = 8;
  localparam int PKT_BYTES   = 13;
  localparam int PKT_W       = BYTE_W * PKT_BYTES;
  localparam int IDX_W       = $clog2(PKT_BYTES);
  localparam int SHORT_LAST  = 8;
  localparam int FULL_LAST   = 12;
  localparam int CHAIN_START = 5;
  localparam logic [1:0] SIZE_WIDE = 2'b11;

  typedef logic [PKT_W-1:0]  pkt_t;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [IDX_W-1:0]  idx_t;

  typedef struct packed {
    logic       wr;
    logic [1:0] size;
    logic [3:0] tag;
    logic       spare;
  } hdr_t;
endpackage

// File: rtl/tx_rst_sync.sv
module tx_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_s_n = sh_q[STAGES-1];
endmodule

// File: rtl/tx_pkt_class.sv
module tx_pkt_class
  import tx_ser_pkg::*;
(
  input  hdr_t hdr,
  output logic is_read,
  output idx_t last_idx
);
  logic full;

  always_comb begin
    is_read  = !hdr.wr;
    full     = is_read || (hdr.size == SIZE_WIDE);
    last_idx = full ? idx_t'(FULL_LAST) : idx_t'(SHORT_LAST);
  end
endmodule

// File: rtl/tx_byte_pick.sv
module tx_byte_pick
  import tx_ser_pkg::*;
(
  input  pkt_t  pkt,
  input  idx_t  idx,
  output byte_t lane
);
  byte_t lanes [PKT_BYTES];

  for (genvar g = 0; g < PKT_BYTES; g++) begin : g_lane
    assign lanes[g] = pkt[PKT_W-1-g*BYTE_W -: BYTE_W];
  end

  always_comb begin
    lane = '0;
    for (int k = 0; k < PKT_BYTES; k++) begin
      if (idx == idx_t'(k)) lane = lanes[k];
    end
  end
endmodule

// File: rtl/tx_launch_gate.sv
module tx_launch_gate (
  input  logic in_valid,
  input  logic in_is_read,
  input  logic rd_wait,
  input  logic wr_wait,
  input  logic idle,
  input  logic at_last,
  input  logic hdr_match,
  output logic in_ready,
  output logic accept,
  output logic chain
);
  logic blocked;
  logic slot_open;

  always_comb begin
    blocked   = in_is_read ? rd_wait : wr_wait;
    slot_open = idle || (at_last && hdr_match);
    in_ready  = !blocked && slot_open;
    accept    = in_valid && in_ready;
    chain     = accept && !idle;
  end
endmodule

// File: rtl/tx_link_serializer.sv
module tx_link_serializer
  import tx_ser_pkg::*;
#(
  parameter int unsigned RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PKT_W-1:0]  in_pkt,
  input  logic              rd_wait,
  input  logic              wr_wait,
  output logic              tx_frame,
  output logic [BYTE_W-1:0] tx_data
);
  logic  rst_s_n;
  hdr_t  in_hdr;
  logic  in_is_read;
  idx_t  in_last;

  logic  frame_q, frame_d;
  idx_t  idx_q, idx_d;
  idx_t  last_q;
  hdr_t  hdr_q;
  pkt_t  pkt_q;
  byte_t data_q, data_d;

  logic  at_last, hdr_match, accept, chain, step;
  pkt_t  sel_pkt;
  idx_t  sel_idx;
  byte_t picked;

  tx_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  assign in_hdr = hdr_t'(in_pkt[PKT_W-1 -: BYTE_W]);

  tx_pkt_class u_class (
    .hdr      (in_hdr),
    .is_read  (in_is_read),
    .last_idx (in_last)
  );

  assign at_last   = frame_q && (idx_q == last_q);
  assign hdr_match = (in_hdr == hdr_q);

  tx_launch_gate u_gate (
    .in_valid   (in_valid),
    .in_is_read (in_is_read),
    .rd_wait    (rd_wait),
    .wr_wait    (wr_wait),
    .idle       (!frame_q),
    .at_last    (at_last),
    .hdr_match  (hdr_match),
    .in_ready   (in_ready),
    .accept     (accept),
    .chain      (chain)
  );

  tx_byte_pick u_pick (
    .pkt  (sel_pkt),
    .idx  (sel_idx),
    .lane (picked)
  );

  // next-state
  always_comb begin
    frame_d = frame_q;
    idx_d   = idx_q;
    sel_pkt = pkt_q;
    sel_idx = idx_q + idx_t'(1);
    if (accept) begin
      frame_d = 1'b1;
      idx_d   = chain ? idx_t'(CHAIN_START) : '0;
      sel_pkt = in_pkt;
      sel_idx = idx_d;
    end else if (frame_q && !at_last) begin
      idx_d   = idx_q + idx_t'(1);
    end else if (frame_q) begin
      frame_d = 1'b0;
      idx_d   = '0;
    end
    data_d = frame_d ? picked : '0;
  end

  assign step = accept || frame_q;

  // sequencing state
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      frame_q <= 1'b0;
      idx_q   <= '0;
      data_q  <= '0;
    end else if (step) begin
      frame_q <= frame_d;
      idx_q   <= idx_d;
      data_q  <= data_d;
    end
  end

  // packet capture
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      last_q <= '0;
      hdr_q  <= '0;
    end else if (accept) begin
      last_q <= in_last;
      hdr_q  <= in_hdr;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) pkt_q <= in_pkt;
  end

  assign tx_frame = frame_q;
  assign tx_data  = data_q;
endmodule

// File: rtl/tx_link_serializer_chk.sv
module tx_link_serializer_chk
  import tx_ser_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [7:0]  in_hdr,
  input logic [7:0]  in_b5,
  input logic        rd_wait,
  input logic        wr_wait,
  input logic        tx_frame,
  input logic [7:0]  tx_data
);
  logic       take;
  logic       take_full;
  idx_t       pos_q;
  logic       full_q;
  logic [7:0] last_hdr_q;

  assign take      = in_valid && in_ready;
  assign take_full = !in_hdr[7] || (in_hdr[6:5] == SIZE_WIDE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q      <= '0;
      full_q     <= 1'b0;
      last_hdr_q <= '0;
    end else if (take) begin
      pos_q      <= tx_frame ? idx_t'(CHAIN_START) : '0;
      full_q     <= take_full;
      last_hdr_q <= in_hdr;
    end else if (tx_frame) begin
      pos_q      <= pos_q + idx_t'(1);
    end
  end

  AST_IDLE_RESET: assert property (@(posedge clk) !rst_n |-> !tx_frame && tx_data == 8'h00); // R1
  AST_GAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !tx_frame |-> tx_data == 8'h00); // R6
  AST_START_HDR: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !tx_frame) |=> (tx_frame && tx_data == $past(in_hdr))); // R10
  AST_CHAIN_B5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && tx_frame) |=> (tx_frame && tx_data == $past(in_b5))); // R5
  AST_CHAIN_HDR: assert property (@(posedge clk) disable iff (!rst_n)
    (take && tx_frame) |-> in_hdr == last_hdr_q); // R5
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !in_hdr[7]) |-> !rd_wait); // R7
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_hdr[7]) |-> !wr_wait); // R8
  AST_SHORT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(tx_frame) && !$past(full_q)) |-> $past(pos_q) == idx_t'(SHORT_LAST)); // R3
  AST_FULL_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(tx_frame) && $past(full_q)) |-> $past(pos_q) == idx_t'(FULL_LAST)); // R4
  AST_NO_CUT: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_frame && pos_q != (full_q ? idx_t'(FULL_LAST) : idx_t'(SHORT_LAST))) |=> tx_frame); // R9
  AST_FRAME_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_frame) |-> $past(take)); // R10
endmodule

bind tx_link_serializer tx_link_serializer_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_s_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_hdr   (in_pkt[103:96]),
  .in_b5    (in_pkt[63:56]),
  .rd_wait  (rd_wait),
  .wr_wait  (wr_wait),
  .tx_frame (tx_frame),
  .tx_data  (tx_data)
);

// File: tb/sim_tx_link_serializer.sv
module sim_tx_link_serializer;
  localparam time CLK_PERIOD = 10ns;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [103:0] in_pkt = '0;
  logic         rd_wait = 1'b0;
  logic         wr_wait = 1'b0;
  logic         tx_frame;
  logic [7:0]   tx_data;

  int vectors = 0;
  int miscompares = 0;

  logic [8:0]   logq [$];
  logic [8:0]   expq [$];
  logic [103:0] pkts [$];
  bit           log_en = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_link_serializer u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pkt(in_pkt), .rd_wait(rd_wait), .wr_wait(wr_wait),
    .tx_frame(tx_frame), .tx_data(tx_data)
  );

  always @(negedge clk) if (log_en) logq.push_back({tx_frame, tx_data});

  function automatic logic [103:0] mk(bit wr, bit [1:0] sz, bit [3:0] tag,
                                      bit [31:0] a, bit [31:0] d, bit [31:0] x);
    return {wr, sz, tag, 1'b0, a, d, x};
  endfunction

  task automatic chk(bit ok, string tag, int act, int expv);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
    end
  endtask

  task automatic add_pkt(logic [103:0] p, bit chained);
    int last = (!p[103] || p[102:101] == 2'b11) ? 12 : 8;
    for (int k = (chained ? 5 : 0); k <= last; k++)
      expq.push_back({1'b1, p[103-8*k -: 8]});
  endtask

  task automatic add_gap();
    expq.push_back(9'h000);
  endtask

  task automatic send_list();
    @(negedge clk);
    foreach (pkts[i]) begin
      in_pkt = pkts[i];
      in_valid = 1'b1;
      #1;
      while (!in_ready) begin
        @(negedge clk);
        #1;
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
    pkts.delete();
  endtask

  task automatic check_trace(string tag, bit exact);
    logic [8:0] t [$];
    int first = -1;
    int last = -1;
    int bad = -1;
    foreach (logq[i]) if (logq[i][8]) begin
      if (first < 0) first = i;
      last = i;
    end
    if (first >= 0) begin
      for (int i = first; i <= last; i++) begin
        if (exact || logq[i][8] || t.size() == 0 || t[t.size()-1][8])
          t.push_back(logq[i]);
      end
    end
    for (int i = 0; i < t.size() && i < expq.size(); i++)
      if (bad < 0 && t[i] !== expq[i]) bad = i;
    if (bad < 0 && t.size() != expq.size())
      chk(0, {tag, " trace length"}, t.size(), expq.size());
    else if (bad >= 0)
      chk(0, $sformatf("%s trace entry %0d", tag, bad), int'(t[bad]), int'(expq[bad]));
    else
      chk(1, tag, 0, 0);
    logq.delete();
    expq.delete();
  endtask

  task automatic run_list(string tag, bit exact);
    logq.delete();
    log_en = 1;
    send_list();
    repeat (18) @(negedge clk);
    log_en = 0;
    check_trace(tag, exact);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    @(negedge clk);
    chk(tx_frame == 1'b0, "R1 frame in reset", tx_frame, 0);
    chk(tx_data == 8'h00, "R1 data in reset", tx_data, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk(tx_frame == 1'b0 && tx_data == 8'h00, "R1 idle after reset", {tx_frame, tx_data}, 0);
    chk(in_ready == 1'b1, "R1 ready when idle", in_ready, 1);
  endtask

  task automatic t_short_write();
    logic [103:0] p = mk(1, 2'b10, 4'h3, 32'h1122_3344, 32'h5566_7788, 32'h99AA_BBCC);
    pkts.push_back(p); add_pkt(p, 0);
    run_list("R3 R2 short write", 1);
  endtask

  task automatic t_full_forms();
    logic [103:0] r = mk(0, 2'b10, 4'h1, 32'hA0A1_A2A3, 32'hB0B1_B2B3, 32'hC0C1_C2C3);
    logic [103:0] w = mk(1, 2'b11, 4'h1, 32'hD0D1_D2D3, 32'hE0E1_E2E3, 32'hF0F1_F2F3);
    pkts.push_back(r); add_pkt(r, 0);
    run_list("R4 read full", 1);
    pkts.push_back(w); add_pkt(w, 0);
    run_list("R4 wide write full", 1);
  endtask

  task automatic t_chain();
    logic [103:0] a = mk(1, 2'b10, 4'h5, 32'h1000_0000, 32'h0102_0304, 32'h0);
    logic [103:0] b = mk(1, 2'b10, 4'h5, 32'h1000_0004, 32'h1112_1314, 32'h0);
    logic [103:0] c = mk(1, 2'b10, 4'h5, 32'h1000_0008, 32'h2122_2324, 32'h0);
    logic [103:0] r1 = mk(0, 2'b10, 4'h2, 32'h2000_0000, 32'h3132_3334, 32'h4142_4344);
    logic [103:0] r2 = mk(0, 2'b10, 4'h2, 32'h2000_0004, 32'h5152_5354, 32'h6162_6364);
    pkts = '{a, b, c};
    add_pkt(a, 0); add_pkt(b, 1); add_pkt(c, 1);
    run_list("R5 chained short writes", 1);
    pkts = '{r1, r2};
    add_pkt(r1, 0); add_pkt(r2, 1);
    run_list("R5 chained reads", 1);
  endtask

  task automatic t_no_chain();
    logic [103:0] a = mk(1, 2'b10, 4'h5, 32'h3000_0000, 32'h7172_7374, 32'h0);
    logic [103:0] b = mk(1, 2'b10, 4'h6, 32'h3000_0004, 32'h8182_8384, 32'h0);
    logic [103:0] r = mk(0, 2'b10, 4'h6, 32'h3000_0008, 32'h9192_9394, 32'hA1A2_A3A4);
    pkts = '{a, b, r};
    add_pkt(a, 0); add_gap(); add_pkt(b, 0); add_gap(); add_pkt(r, 0);
    run_list("R6 header change restarts", 1);
  endtask

  task automatic t_rd_wait();
    logic [103:0] r = mk(0, 2'b10, 4'h7, 32'h4000_0000, 32'hC1C2_C3C4, 32'hD1D2_D3D4);
    logic [103:0] w = mk(1, 2'b00, 4'h7, 32'h4000_0010, 32'hE1E2_E3E4, 32'h0);
    bit ok = 1;
    @(negedge clk);
    rd_wait = 1'b1;
    in_pkt = r; in_valid = 1'b1;
    repeat (6) begin
      @(negedge clk); #1;
      if (in_ready || tx_frame) ok = 0;
    end
    chk(ok, "R7 read held by rd_wait", in_ready, 0);
    in_valid = 1'b0;
    pkts.push_back(w); add_pkt(w, 0);
    run_list("R7 write passes rd_wait", 1);
    rd_wait = 1'b0;
    pkts.push_back(r); add_pkt(r, 0);
    run_list("R7 read after release", 1);
  endtask

  task automatic t_wr_wait();
    logic [103:0] w = mk(1, 2'b01, 4'h8, 32'h5000_0000, 32'h1213_1415, 32'h0);
    logic [103:0] r = mk(0, 2'b01, 4'h8, 32'h5000_0020, 32'h2223_2425, 32'h3233_3435);
    bit ok = 1;
    @(negedge clk);
    wr_wait = 1'b1;
    in_pkt = w; in_valid = 1'b1;
    repeat (6) begin
      @(negedge clk); #1;
      if (in_ready || tx_frame) ok = 0;
    end
    chk(ok, "R8 write held by wr_wait", in_ready, 0);
    in_valid = 1'b0;
    pkts.push_back(r); add_pkt(r, 0);
    run_list("R8 read passes wr_wait", 1);
    wr_wait = 1'b0;
    pkts.push_back(w); add_pkt(w, 0);
    run_list("R8 write after release", 1);
  endtask

  task automatic t_mid_wait();
    logic [103:0] a = mk(0, 2'b10, 4'h9, 32'h6000_0000, 32'h4546_4748, 32'h5556_5758);
    logic [103:0] b = mk(0, 2'b10, 4'h9, 32'h6000_0004, 32'h6566_6768, 32'h7576_7778);
    pkts = '{a, b};
    add_pkt(a, 0); add_gap(); add_pkt(b, 0);
    logq.delete();
    log_en = 1;
    fork
      send_list();
      begin
        repeat (4) @(negedge clk);
        rd_wait = 1'b1;
        repeat (20) @(negedge clk);
        rd_wait = 1'b0;
      end
    join
    repeat (18) @(negedge clk);
    log_en = 0;
    check_trace("R9 wait mid-packet completes packet", 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    t_reset();
    t_short_write();
    t_full_forms();
    t_chain();
    t_no_chain();
    t_rd_wait();
    t_wr_wait();
    t_mid_wait();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule